// File: doc/BRIEF.md
# Pre/Post-Trigger Ring Capture Controller

The block sits behind a free-running sample source and stores every valid sample into a circular buffer. After a rearm strobe it reloads two programmed counts. The first count is the history that must be stored before any trigger is honoured. The second is how many samples are stored after the trigger. When the post-trigger count runs out, writing stops and the buffer holds one contiguous record.

A host then pulls the frozen record out through a simple request/valid read port, oldest sample first. A done flag tells the host that a record is ready. The flag drops when the last entry has been read. If the post-trigger count is smaller than the buffer, the record includes signal from before the event. If it is larger, the record shows a window that starts some time after the event.

An optional auto mode creates a trigger internally when no external trigger pulse has arrived for a programmed number of clock cycles. This keeps the record refreshing on a flat input.

Top module: `ring_trig_capture`

## Requirements
- R1: The buffer has DEPTH = 128 entries; its write position advances by exactly one per stored sample and wraps from 127 to 0.
- R2: While capture is running, each cycle with `smp_valid` high stores `smp_data`. A sample offered in the same cycle as `rearm` is not stored.
- R3: After a rearm, a trigger pulse is discarded until `cfg_pre` samples have been stored since that rearm.
- R4: Only the first accepted trigger starts the post-trigger countdown. Later trigger pulses have no effect until the next rearm.
- R5: After acceptance, exactly `cfg_post` further samples are stored and then capture freezes, with no further writes. With `cfg_post` = 0 the freeze happens in the acceptance cycle.
- R6: With `cfg_post` of at least 128, the record holds only samples that arrived after the trigger: the last 128 of the post-trigger samples.
- R7: `done` rises in the cycle after capture freezes. It stays high across idle cycles and incoming samples, and falls in the cycle after the 128th read request is served.
- R8: With `cfg_auto` = 1, once `cfg_timeout` cycles have passed since the rearm or the last `trig_in` pulse, a trigger is produced internally. With `cfg_auto` = 0 no trigger is ever produced internally.
- R9: Each `rd_req` cycle while `done` is high gives `rd_valid` and `rd_data` one cycle later. The first data returned is the oldest stored sample, and the following reads go forward in time. `rd_req` is ignored while `done` is low.
- R10: `rearm` reloads both counts from the configuration inputs, clears the accepted and done states and restarts reading at the oldest entry. Writing resumes at the current write position, so older contents stay in the record until they are overwritten.
- R11: A trigger in the same cycle as a sample strobe is judged against the pre-trigger count after that sample has been stored. That sample counts as pre-trigger history.
- R12: After reset, capture is stopped, `done` and `rd_valid` are low, and nothing is stored until the first rearm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample value |
| trig_in | input | 1 | Trigger pulse |
| cfg_pre | input | CNT_W | Samples to store before a trigger is honoured |
| cfg_post | input | CNT_W | Samples to store after the accepted trigger |
| cfg_auto | input | 1 | 1 = auto mode, 0 = normal mode |
| cfg_timeout | input | TMR_W | Auto-trigger timeout in clock cycles |
| rearm | input | 1 | Start a new acquisition |
| rd_req | input | 1 | Read the next record entry |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| done | output | 1 | A frozen record is ready |

## Verification
The bench places trigger pulses one sample before and exactly on the sample that satisfies the pre-trigger count. A gate that is off by one would accept too early or too late, and the record would shift by one entry. Triggers are also sent during the post-trigger countdown, which catches a design that restarts the countdown and freezes late. Extra samples are sent after the freeze, and these would show up at the end of the record if writing did not stop. Other runs cover a zero post count, a post count larger than the buffer, and auto mode against normal mode while the input is idle; these expose a missing internal trigger or a spurious one. Read-out of the whole record in order also catches a read start that does not follow the write pointer, and a rearm that resets the pointer instead of resuming at it.

// File: rtl/ring_trig_capture.sv
module ring_trig_capture #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 16,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              trig_in,
  input  logic [CNT_W-1:0]  cfg_pre,
  input  logic [CNT_W-1:0]  cfg_post,
  input  logic              cfg_auto,
  input  logic [TMR_W-1:0]  cfg_timeout,
  input  logic              rearm,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wptr, rd_cnt, rd_ix;
  logic [CNT_W-1:0]  pre_cnt, post_cnt, pre_nx;
  logic [TMR_W-1:0]  to_cnt;
  logic              running, accepted;
  logic              wr, fire, auto_hit, rd_go;

  assign wr       = running && smp_valid && !rearm;
  assign pre_nx   = (wr && pre_cnt != '0) ? pre_cnt - 1'b1 : pre_cnt;
  assign auto_hit = cfg_auto && (to_cnt >= cfg_timeout);
  assign fire     = running && !accepted && !rearm && (pre_nx == '0) && (trig_in || auto_hit);
  assign rd_go    = rd_req && done && !rearm;
  assign rd_ix    = wptr + rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      accepted <= 1'b0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      wptr     <= '0;
      rd_cnt   <= '0;
      pre_cnt  <= '0;
      post_cnt <= '0;
      to_cnt   <= '0;
    end else begin
      rd_valid <= rd_go;
      if (rearm) begin
        running  <= 1'b1;
        accepted <= 1'b0;
        done     <= 1'b0;
        rd_cnt   <= '0;
        pre_cnt  <= cfg_pre;
        post_cnt <= cfg_post;
        to_cnt   <= '0;
      end else begin
        if (wr) wptr <= wptr + 1'b1;
        pre_cnt <= pre_nx;
        if (trig_in)
          to_cnt <= '0;
        else if (running && !accepted && to_cnt != '1)
          to_cnt <= to_cnt + 1'b1;
        if (fire) begin
          accepted <= 1'b1;
          if (post_cnt == '0) begin
            running <= 1'b0;
            done    <= 1'b1;
          end
        end else if (accepted && wr) begin
          post_cnt <= post_cnt - 1'b1;
          if (post_cnt == CNT_W'(1)) begin
            running <= 1'b0;
            done    <= 1'b1;
          end
        end
        if (rd_go) begin
          rd_cnt <= rd_cnt + 1'b1;
          if (rd_cnt == {ADDR_W{1'b1}}) done <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= smp_data;
    if (rd_go) rd_data <= mem[rd_ix];
  end
endmodule

// File: rtl/ring_trig_capture_sva.sv
module ring_trig_capture_sva #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              rearm,
  input logic              rd_req,
  input logic              rd_valid,
  input logic              done,
  input logic              running,
  input logic              accepted,
  input logic [ADDR_W-1:0] wptr
);
  assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    running && smp_valid && !rearm |=> wptr == ADDR_W'($past(wptr) + 1'b1));
  assert_first_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accepted && !rearm |=> accepted);
  assert_frozen_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !rearm |=> $stable(wptr));
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !rd_req && !rearm |=> done);
  assert_done_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running);
  assert_read_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(done) && $past(rd_req));
  assert_rearm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> running && !done && !accepted);
endmodule

bind ring_trig_capture ring_trig_capture_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .rearm(rearm),
  .rd_req(rd_req), .rd_valid(rd_valid), .done(done),
  .running(running), .accepted(accepted), .wptr(wptr)
);

// File: tb/ring_trig_capture_tb.sv
module ring_trig_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_data = '0;
  logic        trig_in = 1'b0;
  logic [15:0] cfg_pre = '0, cfg_post = '0, cfg_timeout = '0;
  logic        cfg_auto = 1'b0;
  logic        rearm = 1'b0;
  logic        rd_req = 1'b0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        done;

  int tests = 0, fails = 0;
  logic [7:0] hist[$];
  logic [7:0] expq[$];
  logic [7:0] val = 8'd1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ring_trig_capture u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .trig_in(trig_in), .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_auto(cfg_auto),
    .cfg_timeout(cfg_timeout), .rearm(rearm), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever the design returns a read
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) chk(0, "R9 unexpected read", rd_data, -1);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(rd_data == e, "R1/R9 record order", rd_data, e);
      end
    end
  end

  task automatic put(input bit t, input bit stored);
    smp_valid = 1'b1; smp_data = val; trig_in = t;
    @(negedge clk);
    smp_valid = 1'b0; trig_in = 1'b0;
    if (stored) hist.push_back(val);
    val = val + 8'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_rearm();
    rearm = 1'b1; smp_valid = 1'b1; smp_data = 8'hEE;   // R2: not stored
    @(negedge clk);
    rearm = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic read_all(input string req);
    int n = hist.size();
    for (int i = n - 128; i < n; i++) expq.push_back(hist[i]);
    for (int i = 0; i < 128; i++) begin
      if (i == 127) chk(done == 1'b1, "R7 done held until last read", done, 1);
      rd_req = 1'b1;
      @(negedge clk);
    end
    rd_req = 1'b0;
    chk(done == 1'b0, "R7 done cleared by final read", done, 0);
    @(negedge clk);
    chk(expq.size() == 0, req, expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(done == 1'b0, "R12 done after reset", done, 0);
    chk(rd_valid == 1'b0, "R12 rd_valid after reset", rd_valid, 0);
    put(1'b1, 1'b0); put(1'b0, 1'b0);
    chk(done == 1'b0, "R12 no capture before rearm", done, 0);

    // Scenario A: pre gate, same-cycle trigger, post count, freeze
    cfg_pre = 16'd130; cfg_post = 16'd20; cfg_auto = 1'b0; cfg_timeout = 16'd5;
    do_rearm();
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    chk(rd_valid == 1'b0, "R9 read ignored while done low", rd_valid, 0);
    for (int i = 1; i <= 130; i++)
      put(i == 6 || i == 129 || i == 130, 1'b1);   // R3 ignores 6,129; R11 accepts 130
    for (int i = 1; i <= 20; i++) begin
      if (i == 20) chk(done == 1'b0, "R5 no early freeze", done, 0);
      put(i == 5 || i == 12, 1'b1);                 // R4 later triggers ignored
    end
    @(negedge clk);
    chk(done == 1'b1, "R5 freeze after post count", done, 1);
    for (int i = 0; i < 5; i++) put(1'b1, 1'b0);   // R5 not stored
    idle(4);
    chk(done == 1'b1, "R7 done holds while idle", done, 1);
    read_all("R3 R4 R5 R11 record");

    // Scenario B: delayed view
    cfg_pre = 16'd0; cfg_post = 16'd200;
    do_rearm();
    put(1'b1, 1'b1);
    for (int i = 0; i < 200; i++) put(i == 50, 1'b1);
    @(negedge clk);
    chk(done == 1'b1, "R6 freeze after 200 post", done, 1);
    put(1'b0, 1'b0); put(1'b0, 1'b0);
    read_all("R6 delayed record");

    // Scenario E: zero post count
    cfg_post = 16'd0;
    do_rearm();
    put(1'b0, 1'b1); put(1'b0, 1'b1); put(1'b0, 1'b1);
    put(1'b1, 1'b1);
    chk(done == 1'b1, "R5 zero post freezes at trigger", done, 1);
    put(1'b0, 1'b0); put(1'b1, 1'b0);
    read_all("R5 R10 zero-post record");

    // Scenario D: normal mode does not self-trigger
    cfg_post = 16'd4; cfg_timeout = 16'd20; cfg_auto = 1'b0;
    do_rearm();
    idle(60);
    put(1'b0, 1'b1); put(1'b0, 1'b1); put(1'b0, 1'b1); put(1'b0, 1'b1); put(1'b0, 1'b1);
    @(negedge clk);
    chk(done == 1'b0, "R8 normal mode no internal trigger", done, 0);
    put(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) put(1'b0, 1'b1);
    @(negedge clk);
    chk(done == 1'b1, "R8 external trigger in normal mode", done, 1);
    read_all("R8 normal record");

    // Scenario C: auto mode fires while idle
    cfg_post = 16'd10; cfg_timeout = 16'd30; cfg_auto = 1'b1;
    do_rearm();
    idle(60);
    for (int i = 1; i <= 10; i++) begin
      if (i == 10) chk(done == 1'b0, "R8 auto post not early", done, 0);
      put(1'b0, 1'b1);
    end
    @(negedge clk);
    chk(done == 1'b1, "R8 auto trigger freeze", done, 1);
    read_all("R8 R10 auto record");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule